// File: doc/BRIEF.md
# Pattern-Word Memory Strobe Sequencer

This block turns one 12-bit pattern word into the control strobes of an external memory access. It drives three outputs: a chip-select, one byte-select per byte lane, and a general-purpose line. The access lasts four quarter-phases, T1 to T4, of one bus cycle. The block runs from a phase clock at four times the bus rate. A start pulse loads the pattern word and the byte-lane enable mask into the block. The block then steps through the four phases on four consecutive phase-clock edges. At each edge every strobe takes the level that its own pattern bit gives for that phase.

The general-purpose line has two controls, each a 2-bit code. One code covers phases T1 and T2, and the other covers T3 and T4. A code can force the line low or high, or it can hand the level to a default bit held in a mode register. Byte lanes that the access does not use stay inactive (high) whatever the pattern says. Between accesses the strobes rest at their inactive levels.

A start pulse that arrives during phase T4 chains a new word directly behind the current one. The bus cycles can therefore run back to back with no idle phase between them.

Top module: `strobe_seq`

## Requirements
- R1: During an access, `cs` shows `pattern[0]`, `pattern[1]`, `pattern[2]` and `pattern[3]` in phases T1, T2, T3 and T4 respectively (1 = high, 0 = low).
- R2: During an access, each enabled byte lane `bs[i]` shows `pattern[4]`, `pattern[5]`, `pattern[6]` and `pattern[7]` in phases T1 to T4 respectively.
- R3: A byte lane whose `lane_en` bit was 0 at start holds `bs[i]` high through all four phases.
- R4: In T1 and T2, `gpl0` follows the code {`pattern[9]`,`pattern[8]`]: when `pattern[9]`=1 the line equals `pattern[8]` (code 10 gives 0, code 11 gives 1); when `pattern[9]`=0 (code 00, or the reserved code 01) the line equals `gpl_default`.
- R5: In T3 and T4, `gpl0` follows the code {`pattern[11]`,`pattern[10]`} with the same encoding as R4.
- R6: When no access is running, `cs` and every `bs` bit are high and `gpl0` equals `gpl_default`, from the first clock edge after reset is released.
- R7: The edge that samples `start` high while the block is idle shows the T1 levels. The next three edges show T2, T3 and T4, and the edge after that returns to idle.
- R8: The block latches `pattern` and `lane_en` at the loading edge, so changes on those inputs during T1 to T4 do not alter the current access.
- R9: `start` is ignored while the outputs show T1, T2 or T3. A `start` sampled while they show T4 loads a new word, whose T1 levels appear on the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, four edges per bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load request for a new pattern word |
| pattern | input | 12 | Pattern word for one access |
| lane_en | input | LANES | Byte lanes used by the access (1 = used) |
| gpl_default | input | 1 | Mode-register default for the general-purpose line |
| cs | output | 1 | Chip-select strobe |
| bs | output | LANES | Byte-select strobes, one per lane |
| gpl0 | output | 1 | General-purpose line |

## Verification
The bench sweeps all 4096 pattern words, including every code of both general-purpose fields. Each word gets its own lane mask and default level. A design that read the fields in the wrong order would give the wrong level on the line. So would one that treated the reserved code as a forced level. A design that let unused lanes follow the pattern would be caught by the sweep as well.

After each start, the bench inverts the `pattern` and `lane_en` inputs, which exposes a design that samples those inputs live rather than latching them. It also raises `start` during T2 for some words. A block that accepted that pulse would restart the word early. Other words are chained by a start pulse held during T4. A block that inserted an idle phase, or lost the chained word, would show idle or stale levels where the new T1 was expected.

// File: rtl/strobe_seq.sv
module strobe_seq #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [11:0]      pattern,
  input  logic [LANES-1:0] lane_en,
  input  logic             gpl_default,
  output logic             cs,
  output logic [LANES-1:0] bs,
  output logic             gpl0
);
  localparam logic [1:0] LAST = 2'd3;

  logic             act;
  logic [1:0]       ph;
  logic [11:0]      pat;
  logic [LANES-1:0] lanes;

  logic             act_n;
  logic [1:0]       ph_n;
  logic [11:0]      pat_n;
  logic [LANES-1:0] lanes_n;
  logic             cs_n;
  logic [LANES-1:0] bs_n;
  logic             gp_n;
  logic [1:0]       gfield;
  logic [3:0]       bs_bits;

  wire load = start && (!act || ph == LAST);

  assign act_n   = load || (act && ph != LAST);
  assign ph_n    = load ? 2'd0 : ph + 2'd1;
  assign pat_n   = load ? pattern : pat;
  assign lanes_n = load ? lane_en : lanes;
  assign bs_bits = pat_n[7:4];
  assign gfield  = ph_n[1] ? pat_n[11:10] : pat_n[9:8];

  always_comb begin
    cs_n = 1'b1;
    bs_n = '1;
    gp_n = gpl_default;
    if (act_n) begin
      cs_n = pat_n[ph_n];
      for (int i = 0; i < LANES; i++)
        bs_n[i] = lanes_n[i] ? bs_bits[ph_n] : 1'b1;
      if (gfield[1]) gp_n = gfield[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act   <= 1'b0;
      ph    <= 2'd0;
      pat   <= '0;
      lanes <= '0;
      cs    <= 1'b1;
      bs    <= '1;
      gpl0  <= 1'b0;
    end else begin
      act   <= act_n;
      ph    <= act_n ? ph_n : 2'd0;
      pat   <= pat_n;
      lanes <= lanes_n;
      cs    <= cs_n;
      bs    <= bs_n;
      gpl0  <= gp_n;
    end
  end
endmodule

module strobe_seq_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [11:0]      pattern,
  input logic [LANES-1:0] lane_en,
  input logic             gpl_default,
  input logic             cs,
  input logic [LANES-1:0] bs,
  input logic             gpl0
);
  logic             ck_act;
  logic [1:0]       ck_ph;
  logic [11:0]      ck_pat;
  logic [LANES-1:0] ck_lane;
  logic [3:0]       ck_bs;
  logic             ck_take;

  assign ck_bs   = ck_pat[7:4];
  assign ck_take = start && (!ck_act || ck_ph == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_act  <= 1'b0;
      ck_ph   <= 2'd0;
      ck_pat  <= '0;
      ck_lane <= '0;
    end else if (ck_take) begin
      ck_act  <= 1'b1;
      ck_ph   <= 2'd0;
      ck_pat  <= pattern;
      ck_lane <= lane_en;
    end else if (ck_act) begin
      ck_act <= (ck_ph != 2'd3);
      ck_ph  <= ck_ph + 2'd1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ck_act |-> (cs && (&bs))); // R6
  AST_CS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    ck_act |-> (cs == ck_pat[ck_ph])); // R1
  AST_BS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    ck_act |-> (((bs ^ {LANES{ck_bs[ck_ph]}}) & ck_lane) == '0)); // R2
  AST_DEAD_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    ck_act |-> ((bs | ck_lane) == '1)); // R3
  AST_GP_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_act && !ck_ph[1] && ck_pat[9]) |-> (gpl0 == ck_pat[8])); // R4
  AST_GP_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_act && ck_ph[1] && ck_pat[11]) |-> (gpl0 == ck_pat[10])); // R5
endmodule

bind strobe_seq strobe_seq_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/sim_strobe_seq.sv
module sim_strobe_seq;
  localparam int LANES = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [11:0]      pattern = '0;
  logic [LANES-1:0] lane_en = '0;
  logic             gpl_default = 1'b0;
  logic             cs;
  logic [LANES-1:0] bs;
  logic             gpl0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  strobe_seq #(.LANES(LANES)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // p = -1 means idle
  task automatic check_out(input int p, input logic [11:0] w, input logic [LANES-1:0] ln,
                           input logic d, input string tag);
    logic             e_cs;
    logic [LANES-1:0] e_bs;
    logic             e_gp;
    logic [1:0]       f;
    if (p < 0) begin
      e_cs = 1'b1; e_bs = '1; e_gp = d;
    end else begin
      e_cs = w[p];
      for (int i = 0; i < LANES; i++) e_bs[i] = ln[i] ? w[4+p] : 1'b1;
      f = (p < 2) ? {w[9], w[8]} : {w[11], w[10]};
      e_gp = f[1] ? f[0] : d;
    end
    chk(cs === e_cs, (p < 0) ? {"R6 cs ", tag} : {"R1 cs ", tag}, cs, e_cs);
    chk(bs === e_bs, (p < 0) ? {"R6 bs ", tag} : {"R2/R3 bs ", tag}, bs, e_bs);
    chk(gpl0 === e_gp, (p < 0) ? {"R6 gpl0 ", tag} : ((p < 2) ? {"R4 gpl0 ", tag} : {"R5 gpl0 ", tag}), gpl0, e_gp);
  endtask

  initial begin
    logic [11:0]      w;
    logic [LANES-1:0] ln;
    logic             d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    gpl_default = 1'b1;
    @(negedge clk);
    check_out(-1, '0, '0, 1'b1, "after reset");
    for (int i = 0; i < 4096; i++) begin
      w  = i[11:0];
      ln = i[3:0] ^ i[7:4] ^ i[11:8];
      d  = i[0] ^ i[5];
      pattern = w;
      lane_en = ln;
      gpl_default = d;
      start = 1'b1;
      for (int p = 0; p < 4; p++) begin
        @(negedge clk);
        if (p == 0) begin
          start = 1'b0;
          pattern = ~w;        // R8: inputs move after the load
          lane_en = ~ln;
        end
        if (p == 1 && (i % 5) == 0) start = 1'b1;  // R9: ignored mid-access
        if (p == 2) start = 1'b0;
        check_out(p, w, ln, d, (p == 0) ? "R7 T1" : "R8/R9 phase");
      end
      if ((i % 3) == 0) begin
        @(negedge clk);
        check_out(-1, w, ln, d, "R7 idle after T4");
      end
      // otherwise the next word is chained from T4 (R9)
    end
    @(negedge clk);
    check_out(-1, '0, '0, gpl_default, "R6 final idle");
    gpl_default = ~gpl_default;
    @(negedge clk);
    check_out(-1, '0, '0, gpl_default, "R6 default follows");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule